// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns a four-bit binary-coded decimal digit into the seven segment drive levels of a numeric display. The digit goes through a storage register. While the hold input is low, the register reloads from the data inputs on every clock. While hold is high, it keeps the last digit it captured, so the data bus can be shared or changed without disturbing the display.

Two active-low overrides sit after the decoder. The test input lights every segment, and it wins over everything else. The blank input darkens every segment when the test input is inactive. Neither override reaches the stored digit, so the digit underneath reappears as soon as both overrides are released. Codes above nine show as a dark display. A static parameter inverts all seven outputs after the override logic, for displays that light a segment on a low level.

Top module: `bcd_seg_latch`

## Requirements
- R1: A synchronous active-high reset clears the stored digit to zero, so with both overrides inactive the output shows the zero pattern.
- R2: While hold_en is low, the stored digit reloads from bcd_in on every rising clock edge, and seg_out shows the new digit in the cycle after the edge that captured it.
- R3: While hold_en is high, the stored digit keeps its value, and changes on bcd_in leave seg_out unchanged.
- R4: seg_out bit 6 drives segment a and bit 0 drives segment g, with 1 meaning lit. The digits decode as 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=0011111, 7=1110000, 8=1111111 and 9=1110011.
- R5: Stored codes 10 through 15 give all seven segments dark.
- R6: With test_n low, all seven segments are lit whatever the state of the other inputs.
- R7: With test_n high and blank_n low, all seven segments are dark.
- R8: test_n and blank_n never change the stored digit. Once both are released, the digit held before the override is shown again.
- R9: With the INVERT parameter set, every output bit is the complement of the lit pattern that R4 to R7 give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_in | input | 4 | Digit to decode |
| hold_en | input | 1 | High keeps the stored digit; low lets it reload |
| blank_n | input | 1 | Active-low blanking |
| test_n | input | 1 | Active-low test that lights every segment |
| seg_out | output | 7 | Segment drive, a in bit 6 down to g in bit 0 |

## Verification
All sixteen codes are swept with hold low and both overrides inactive. This separates each decimal glyph from the others and from the dark pattern that codes ten to fifteen give. The data bus is then changed while hold is high, which shows whether the register really holds or still follows the inputs. Every combination of the two overrides is applied over a held digit and then released. This proves that test wins over blank, and that the glyph which returns afterwards is the stored one. A second instance built with inversion runs against the complemented reference on every clock.

// File: rtl/bcd_seg_latch.sv
module bcd_seg_latch #(
  parameter bit INVERT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] bcd_in,
  input  logic       hold_en,
  input  logic       blank_n,
  input  logic       test_n,
  output logic [6:0] seg_out
);

  localparam logic [6:0] ALL_ON  = 7'h7f;
  localparam logic [6:0] ALL_OFF = 7'h00;

  logic [3:0] digit_q;
  logic [6:0] glyph;
  logic [6:0] shown;

  always_ff @(posedge clk) begin
    if (rst)
      digit_q <= 4'd0;
    else if (!hold_en)
      digit_q <= bcd_in;
  end

  always_comb begin
    case (digit_q)
      4'd0:    glyph = 7'b1111110;
      4'd1:    glyph = 7'b0110000;
      4'd2:    glyph = 7'b1101101;
      4'd3:    glyph = 7'b1111001;
      4'd4:    glyph = 7'b0110011;
      4'd5:    glyph = 7'b1011011;
      4'd6:    glyph = 7'b0011111;
      4'd7:    glyph = 7'b1110000;
      4'd8:    glyph = 7'b1111111;
      4'd9:    glyph = 7'b1110011;
      default: glyph = ALL_OFF;
    endcase
  end

  assign shown   = !test_n ? ALL_ON : (!blank_n ? ALL_OFF : glyph);
  assign seg_out = INVERT ? ~shown : shown;

endmodule

// File: rtl/bcd_seg_latch_chk.sv
module bcd_seg_latch_chk #(
  parameter bit INVERT = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] bcd_in,
  input logic       hold_en,
  input logic       blank_n,
  input logic       test_n,
  input logic [6:0] seg_out
);

  localparam logic [6:0] LIT  = INVERT ? 7'h00 : 7'h7f;
  localparam logic [6:0] DARK = INVERT ? 7'h7f : 7'h00;

  // R6
  test_lit_chk: assert property (@(posedge clk) disable iff (rst)
    !test_n |-> seg_out == LIT);

  // R7
  blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (test_n && !blank_n) |-> seg_out == DARK);

  // R3
  hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hold_en) && test_n && blank_n && $past(test_n) && $past(blank_n))
      |-> $stable(seg_out));

  // R5
  invalid_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hold_en) && $past(bcd_in) >= 4'd10 && test_n && blank_n)
      |-> seg_out == DARK);

endmodule

bind bcd_seg_latch bcd_seg_latch_chk #(.INVERT(INVERT)) u_chk (
  .clk(clk), .rst(rst), .bcd_in(bcd_in), .hold_en(hold_en),
  .blank_n(blank_n), .test_n(test_n), .seg_out(seg_out)
);

// File: tb/sim_bcd_seg_latch.sv
module sim_bcd_seg_latch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bcd_in = 4'd5;
  logic       hold_en = 1'b0;
  logic       blank_n = 1'b1;
  logic       test_n = 1'b1;
  logic [6:0] seg0, seg1;

  int checks = 0;
  int fails = 0;
  int model_digit = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_seg_latch #(.INVERT(1'b0)) u0 (.clk(clk), .rst(rst), .bcd_in(bcd_in), .hold_en(hold_en),
    .blank_n(blank_n), .test_n(test_n), .seg_out(seg0));
  bcd_seg_latch #(.INVERT(1'b1)) u1 (.clk(clk), .rst(rst), .bcd_in(bcd_in), .hold_en(hold_en),
    .blank_n(blank_n), .test_n(test_n), .seg_out(seg1));

  function automatic logic [6:0] pattern(int d);
    logic [6:0] p;
    p = 7'h00;
    if (d <= 9) begin
      if (d != 1 && d != 4 && d != 6)                   p[6] = 1'b1;
      if (d != 5 && d != 6)                              p[5] = 1'b1;
      if (d != 2)                                        p[4] = 1'b1;
      if (d != 1 && d != 4 && d != 7 && d != 9)          p[3] = 1'b1;
      if (d == 0 || d == 2 || d == 6 || d == 8)          p[2] = 1'b1;
      if (d == 0 || d == 4 || d == 5 || d == 6 || d >= 8) p[1] = 1'b1;
      if (d >= 2 && d != 7)                              p[0] = 1'b1;
    end
    return p;
  endfunction

  function automatic logic [6:0] expect_now();
    if (!test_n) return 7'h7f;
    if (!blank_n) return 7'h00;
    return pattern(model_digit);
  endfunction

  task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always begin
    @(posedge clk);
    if (rst) model_digit = 0;
    else if (!hold_en) model_digit = int'(bcd_in);
    #2;
    if (!rst) begin
      string tag;
      if (!test_n) tag = "R6";
      else if (!blank_n) tag = "R7";
      else if (model_digit >= 10) tag = "R5";
      else tag = "R4";
      check(tag, seg0, expect_now());
      check("R9", seg1, ~expect_now());
    end
  end

  task automatic drive(logic [3:0] d, logic h, logic b, logic t);
    @(negedge clk);
    bcd_in = d; hold_en = h; blank_n = b; test_n = t;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0; hold_en = 1'b1;
    settle();
    check("R1", seg0, 7'b1111110);

    drive(4'd7, 1'b0, 1'b1, 1'b1);
    settle();
    check("R2", seg0, 7'b1110000);

    for (int i = 0; i < 16; i++) begin
      drive(i[3:0], 1'b0, 1'b1, 1'b1);
      settle();
      if (i >= 10) check("R5", seg0, 7'h00);
      else check("R4", seg0, pattern(i));
    end

    drive(4'd3, 1'b0, 1'b1, 1'b1);
    drive(4'd3, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++) begin
      drive(i[3:0], 1'b1, 1'b1, 1'b1);
      settle();
      check("R3", seg0, 7'b1111001);
    end

    drive(4'd8, 1'b1, 1'b0, 1'b0);
    settle();
    check("R6", seg0, 7'h7f);
    drive(4'd1, 1'b1, 1'b1, 1'b0);
    settle();
    check("R6", seg0, 7'h7f);
    drive(4'd2, 1'b1, 1'b0, 1'b1);
    settle();
    check("R7", seg0, 7'h00);
    drive(4'd9, 1'b1, 1'b1, 1'b1);
    settle();
    check("R8", seg0, 7'b1111001);

    drive(4'd6, 1'b0, 1'b0, 1'b1);
    drive(4'd4, 1'b0, 1'b1, 1'b0);
    drive(4'd4, 1'b1, 1'b1, 1'b1);
    settle();
    check("R8", seg0, 7'b0110011);
    check("R9", seg1, ~7'b0110011);

    for (int i = 0; i < 40; i++) begin
      drive(4'((i * 7 + 3) % 16), (i % 5) == 2, (i % 3) != 0, (i % 7) != 4);
    end
    repeat (3) @(posedge clk);
    #3;
    summary();
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule